// File: doc/BRIEF.md
# Multiframe Marker and Maintenance Bit Handler

This block sits beside the frame assembler and disassembler of a basic-rate S interface. It deals with the multiframe marker, the maintenance (Q) channel bits and the M and S bits. It works in one of two modes. In network mode it puts the multiframe marker into the outgoing FA/N bit pair. In the frame after a marker it returns the Q bit that arrives in the received FA position. In terminal mode it detects a received marker (FA = 1, N = 0) and reports it. In the next frame it sends the local maintenance bit in the FA and L positions.

The marker, maintenance and M/S pins change direction with the mode. Each appears as a separate input, output and output-enable. Every pin is sampled or updated on a chosen edge of the half-frame signal. The half-frame signal is high in the first half of a frame, so its rising edge marks a frame boundary. The clock is far faster than the bit rate.

Bits move to and from the frame logic as single-cycle strobes, one per bit slot. The slots are fixed by line timing and cannot wait, so there is no back-pressure: a strobe always consumes its bit in the cycle it appears. The transmit values are levels that hold for the whole frame.

Top module: `mfq_handler`

## Requirements
- R1: After reset, mark_out, maint_out, msb_out, tx_fa, tx_l_ovr, tx_l, tx_m and tx_s are 0. In network mode tx_n is 1.
- R2: In network mode (net_mode = 1), mark_in is sampled only on the clock edge where half_frame is first seen high. For the frame that follows, tx_fa = 1 and tx_n = 0 when the sample was 1. Changes of mark_in at any other time leave tx_fa unchanged.
- R3: In network mode, a frame whose mark_in sample was 0 sends tx_fa = 0 and tx_n = 1.
- R4: In network mode, an rx_fa_stb pulse loads rx_fa into maint_out only in the frame right after a frame that sent a marker. In any other frame, rx_fa_stb leaves maint_out unchanged.
- R5: In terminal mode (net_mode = 0), a frame whose rx_fa_stb bit was 1 and whose later rx_n_stb bit was 0 sets mark_out to 1 at the next rising edge of half_frame. Otherwise mark_out is 0 at that edge. mark_out changes at no other time.
- R6: In terminal mode, maint_in is sampled on the falling edge of half_frame. In the frame after a detected marker, tx_l_ovr = 1 and tx_fa = tx_l = the last sample. In other frames tx_l_ovr, tx_fa and tx_l are 0.
- R7: In network mode, msb_in is captured into tx_m while half_frame is 1 and into tx_s while half_frame is 0.
- R8: In terminal mode, msb_out shows the bit last strobed by rx_m_stb while half_frame is 1, and the bit last strobed by rx_s_stb while half_frame is 0. It is registered, so it appears one cycle after its inputs.
- R9: mark_oe = msb_oe = NOT net_mode and maint_oe = net_mode. In network mode, mark_out and msb_out stay 0.
- R10: In terminal mode tx_n is 0. In network mode tx_l_ovr and tx_l are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_mode | input | 1 | 1 = network side, 0 = terminal side |
| half_frame | input | 1 | High in the first half of each frame |
| mark_in | input | 1 | Marker request (network mode) |
| mark_out | output | 1 | Marker received (terminal mode) |
| mark_oe | output | 1 | Marker pin drives when 1 |
| maint_in | input | 1 | Local Q bit (terminal mode) |
| maint_out | output | 1 | Returned Q bit (network mode) |
| maint_oe | output | 1 | Maintenance pin drives when 1 |
| msb_in | input | 1 | M/S bit from pin (network mode) |
| msb_out | output | 1 | M/S bit to pin (terminal mode) |
| msb_oe | output | 1 | M/S pin drives when 1 |
| rx_fa_stb | input | 1 | Received FA bit strobe |
| rx_fa | input | 1 | Received FA bit |
| rx_n_stb | input | 1 | Received N bit strobe |
| rx_n | input | 1 | Received N bit |
| rx_m_stb | input | 1 | Received M bit strobe |
| rx_m | input | 1 | Received M bit |
| rx_s_stb | input | 1 | Received S bit strobe |
| rx_s | input | 1 | Received S bit |
| tx_fa | output | 1 | FA bit to transmit this frame |
| tx_n | output | 1 | N bit to transmit this frame |
| tx_l_ovr | output | 1 | L bit position carries tx_l this frame |
| tx_l | output | 1 | L bit value when overridden |
| tx_m | output | 1 | M bit to transmit |
| tx_s | output | 1 | S bit to transmit |

## Verification
The frame-level results (tx_fa, tx_n, mark_out, tx_l_ovr, tx_l) are due one cycle after the clock edge that first sees a new half_frame level. maint_out, tx_m and tx_s are due one cycle after the strobe or sample edge. msb_out is due one cycle after both the captured bit and the half-frame level have settled. When it drives a stimulus, the driver pushes each expected value with the exact due cycle counted from this register path. The monitor compares values on the falling clock edge only when that cycle is reached. Frames also include deliberate changes of mark_in and maint_in away from their sample edges, which must leave the outputs unchanged.

// File: rtl/mfq_pkg.sv
package mfq_pkg;
  typedef enum logic {
    SIDE_TERM = 1'b0,
    SIDE_NET  = 1'b1
  } side_e;
endpackage

// File: rtl/mfq_half_edge.sv
module mfq_half_edge #(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_i,
  output logic half_o,
  output logic rise_o,
  output logic fall_o
);
  logic half_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign half_o = half_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else begin
          chain[0] <= half_i;
          for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign half_o = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_o;
  end

  assign rise_o = half_o & ~half_q;
  assign fall_o = ~half_o & half_q;
endmodule

// File: rtl/mfq_net_side.sv
module mfq_net_side (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise,
  input  logic mark_in,
  input  logic rx_fa_stb,
  input  logic rx_fa,
  output logic mark_req,
  output logic maint_q
);
  logic window;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark_req <= 1'b0;
      window   <= 1'b0;
      maint_q  <= 1'b0;
    end else if (en) begin
      if (rise) begin
        mark_req <= mark_in;
        window   <= mark_req;
      end
      if (rx_fa_stb && window) maint_q <= rx_fa;
    end
  end
endmodule

// File: rtl/mfq_term_side.sv
module mfq_term_side (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise,
  input  logic fall,
  input  logic maint_in,
  input  logic rx_fa_stb,
  input  logic rx_fa,
  input  logic rx_n_stb,
  input  logic rx_n,
  output logic mark_det,
  output logic slot,
  output logic q_hold
);
  logic fa_seen;
  logic hit;
  logic q_smp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fa_seen  <= 1'b0;
      hit      <= 1'b0;
      q_smp    <= 1'b0;
      mark_det <= 1'b0;
      slot     <= 1'b0;
      q_hold   <= 1'b0;
    end else if (en) begin
      if (rx_fa_stb) fa_seen <= rx_fa;
      if (fall) q_smp <= maint_in;
      if (rise) begin
        mark_det <= hit;
        slot     <= hit;
        q_hold   <= q_smp;
        hit      <= 1'b0;
      end else if (rx_n_stb && fa_seen && !rx_n) begin
        hit <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mfq_ms_port.sv
module mfq_ms_port (
  input  logic clk,
  input  logic rst_n,
  input  logic is_net,
  input  logic half,
  input  logic msb_in,
  input  logic rx_m_stb,
  input  logic rx_m,
  input  logic rx_s_stb,
  input  logic rx_s,
  output logic tx_m,
  output logic tx_s,
  output logic msb_out
);
  logic m_rx;
  logic s_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_m    <= 1'b0;
      tx_s    <= 1'b0;
      m_rx    <= 1'b0;
      s_rx    <= 1'b0;
      msb_out <= 1'b0;
    end else begin
      if (is_net) begin
        if (half) tx_m <= msb_in;
        else      tx_s <= msb_in;
      end else begin
        if (rx_m_stb) m_rx <= rx_m;
        if (rx_s_stb) s_rx <= rx_s;
      end
      msb_out <= ~is_net & (half ? m_rx : s_rx);
    end
  end
endmodule

// File: rtl/mfq_handler.sv
module mfq_handler
  import mfq_pkg::*;
#(
  parameter int HALF_SYNC = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic net_mode,
  input  logic half_frame,
  input  logic mark_in,
  output logic mark_out,
  output logic mark_oe,
  input  logic maint_in,
  output logic maint_out,
  output logic maint_oe,
  input  logic msb_in,
  output logic msb_out,
  output logic msb_oe,
  input  logic rx_fa_stb,
  input  logic rx_fa,
  input  logic rx_n_stb,
  input  logic rx_n,
  input  logic rx_m_stb,
  input  logic rx_m,
  input  logic rx_s_stb,
  input  logic rx_s,
  output logic tx_fa,
  output logic tx_n,
  output logic tx_l_ovr,
  output logic tx_l,
  output logic tx_m,
  output logic tx_s
);
  logic is_net;
  logic half_s, rise, fall;
  logic mark_req, maint_q;
  logic mark_det, slot, q_hold;

  assign is_net = (side_e'(net_mode) == SIDE_NET);

  mfq_half_edge #(.SYNC_STAGES(HALF_SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .half_i(half_frame),
    .half_o(half_s), .rise_o(rise), .fall_o(fall)
  );

  mfq_net_side u_net (
    .clk(clk), .rst_n(rst_n), .en(is_net), .rise(rise),
    .mark_in(mark_in), .rx_fa_stb(rx_fa_stb), .rx_fa(rx_fa),
    .mark_req(mark_req), .maint_q(maint_q)
  );

  mfq_term_side u_term (
    .clk(clk), .rst_n(rst_n), .en(~is_net), .rise(rise), .fall(fall),
    .maint_in(maint_in), .rx_fa_stb(rx_fa_stb), .rx_fa(rx_fa),
    .rx_n_stb(rx_n_stb), .rx_n(rx_n),
    .mark_det(mark_det), .slot(slot), .q_hold(q_hold)
  );

  mfq_ms_port u_ms (
    .clk(clk), .rst_n(rst_n), .is_net(is_net), .half(half_s),
    .msb_in(msb_in), .rx_m_stb(rx_m_stb), .rx_m(rx_m),
    .rx_s_stb(rx_s_stb), .rx_s(rx_s),
    .tx_m(tx_m), .tx_s(tx_s), .msb_out(msb_out)
  );

  assign tx_fa     = is_net ? mark_req : (slot & q_hold);
  assign tx_n      = is_net & ~mark_req;
  assign tx_l_ovr  = ~is_net & slot;
  assign tx_l      = ~is_net & slot & q_hold;
  assign mark_out  = ~is_net & mark_det;
  assign maint_out = is_net & maint_q;
  assign mark_oe   = ~is_net;
  assign msb_oe    = ~is_net;
  assign maint_oe  = is_net;
endmodule

// File: rtl/mfq_handler_chk.sv
module mfq_handler_chk (
  input logic clk,
  input logic rst_n,
  input logic net_mode,
  input logic half_s,
  input logic msb_in,
  input logic rx_fa_stb,
  input logic mark_out,
  input logic maint_out,
  input logic msb_out,
  input logic tx_fa,
  input logic tx_n,
  input logic tx_l_ovr,
  input logic tx_l,
  input logic tx_m
);
  logic prev_half;
  logic edge_up;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_half <= 1'b0;
    else        prev_half <= half_s;
  end
  assign edge_up = half_s & ~prev_half;

  AST_MARK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    net_mode && !edge_up |=> $stable(tx_fa)); // R2
  AST_N_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    net_mode |-> tx_n != tx_fa); // R3
  AST_MAINT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    net_mode && !rx_fa_stb |=> $stable(maint_out)); // R4
  AST_MARKOUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !net_mode && !edge_up |=> $stable(mark_out)); // R5
  AST_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !net_mode && !tx_l_ovr |-> !tx_fa && !tx_l); // R6
  AST_M_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    net_mode && half_s |=> tx_m == $past(msb_in)); // R7
  AST_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    net_mode |-> !mark_out && !msb_out); // R9
endmodule

bind mfq_handler mfq_handler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .net_mode(net_mode), .half_s(half_s),
  .msb_in(msb_in), .rx_fa_stb(rx_fa_stb), .mark_out(mark_out),
  .maint_out(maint_out), .msb_out(msb_out), .tx_fa(tx_fa), .tx_n(tx_n),
  .tx_l_ovr(tx_l_ovr), .tx_l(tx_l), .tx_m(tx_m)
);

// File: tb/sim_mfq_handler.sv
module sim_mfq_handler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic net_mode = 1'b1, half_frame = 1'b0, mark_in = 1'b0, maint_in = 1'b0, msb_in = 1'b0;
  logic rx_fa_stb = 1'b0, rx_fa = 1'b0, rx_n_stb = 1'b0, rx_n = 1'b0;
  logic rx_m_stb = 1'b0, rx_m = 1'b0, rx_s_stb = 1'b0, rx_s = 1'b0;
  logic mark_out, mark_oe, maint_out, maint_oe, msb_out, msb_oe;
  logic tx_fa, tx_n, tx_l_ovr, tx_l, tx_m, tx_s;

  localparam int S_MARK = 0, S_MAINT = 1, S_MSB = 2, S_FA = 3, S_N = 4, S_LOVR = 5,
                 S_L = 6, S_M = 7, S_S = 8, S_MOE = 9, S_QOE = 10, S_SOE = 11;

  typedef struct {
    int    due;
    int    sig;
    logic  val;
    string req;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mfq_handler u0 (
    .clk(clk), .rst_n(rst_n), .net_mode(net_mode), .half_frame(half_frame),
    .mark_in(mark_in), .mark_out(mark_out), .mark_oe(mark_oe),
    .maint_in(maint_in), .maint_out(maint_out), .maint_oe(maint_oe),
    .msb_in(msb_in), .msb_out(msb_out), .msb_oe(msb_oe),
    .rx_fa_stb(rx_fa_stb), .rx_fa(rx_fa), .rx_n_stb(rx_n_stb), .rx_n(rx_n),
    .rx_m_stb(rx_m_stb), .rx_m(rx_m), .rx_s_stb(rx_s_stb), .rx_s(rx_s),
    .tx_fa(tx_fa), .tx_n(tx_n), .tx_l_ovr(tx_l_ovr), .tx_l(tx_l),
    .tx_m(tx_m), .tx_s(tx_s)
  );

  function automatic logic peek(int sig);
    case (sig)
      S_MARK:  return mark_out;
      S_MAINT: return maint_out;
      S_MSB:   return msb_out;
      S_FA:    return tx_fa;
      S_N:     return tx_n;
      S_LOVR:  return tx_l_ovr;
      S_L:     return tx_l;
      S_M:     return tx_m;
      S_S:     return tx_s;
      S_MOE:   return mark_oe;
      S_QOE:   return maint_oe;
      default: return msb_oe;
    endcase
  endfunction

  task automatic expect_at(int dly, int sig, logic val, string req);
    item_t it;
    it.due = cyc + dly; it.sig = sig; it.val = val; it.req = req;
    sbq.push_back(it);
  endtask

  // monitor: compares each expected item in its due cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      logic act;
      it = sbq.pop_front();
      act = peek(it.sig);
      checks++;
      if (act !== it.val || it.due != cyc) begin
        errors++;
        $display("FAIL %s sig=%0d cycle=%0d actual=%b expected=%b", it.req, it.sig, cyc, act, it.val);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(logic mode);
    step();
    rst_n = 1'b0; net_mode = mode; half_frame = 1'b0;
    step(); step();
    rst_n = 1'b1;
    expect_at(1, S_FA, 1'b0, "R1");
    expect_at(1, S_N, mode, "R1");
    expect_at(1, S_MARK, 1'b0, "R1");
    expect_at(1, S_MAINT, 1'b0, "R1");
    expect_at(1, S_MSB, 1'b0, "R1");
    expect_at(1, S_LOVR, 1'b0, "R1");
    expect_at(1, S_M, 1'b0, "R1");
    expect_at(1, S_S, 1'b0, "R1");
    expect_at(1, S_MOE, ~mode, "R9");
    expect_at(1, S_QOE, mode, "R9");
    expect_at(1, S_SOE, ~mode, "R9");
    step();
  endtask

  // network-mode model state
  logic nt_prev_mk = 1'b0;
  logic nt_q = 1'b0;

  task automatic nt_frame(logic mk, logic fav, logic mv, logic sv);
    logic window;
    step();
    half_frame = 1'b1; mark_in = mk; msb_in = mv;
    window = nt_prev_mk; nt_prev_mk = mk;
    expect_at(1, S_FA, mk, mk ? "R2" : "R3");
    expect_at(1, S_N, ~mk, mk ? "R2" : "R3");
    expect_at(1, S_M, mv, "R7");
    expect_at(1, S_LOVR, 1'b0, "R10");
    step();
    mark_in = ~mk;                      // R2: ignored away from the rising edge
    step();
    rx_fa_stb = 1'b1; rx_fa = fav;
    if (window) nt_q = fav;
    expect_at(1, S_MAINT, nt_q, "R4");
    step();
    rx_fa_stb = 1'b0;
    expect_at(1, S_FA, mk, "R2");
    step();
    half_frame = 1'b0; msb_in = sv;
    expect_at(1, S_S, sv, "R7");
    expect_at(1, S_M, mv, "R7");
    expect_at(1, S_MARK, 1'b0, "R9");
    expect_at(1, S_MSB, 1'b0, "R9");
    step(); step();
  endtask

  // terminal-mode model state
  logic te_hit = 1'b0;
  logic te_qs = 1'b0;

  task automatic te_frame(logic fa, logic n, logic qv, logic mv, logic sv);
    step();
    half_frame = 1'b1; rx_m_stb = 1'b1; rx_m = mv; rx_s_stb = 1'b1; rx_s = sv;
    expect_at(1, S_MARK, te_hit, "R5");
    expect_at(1, S_LOVR, te_hit, "R6");
    expect_at(1, S_FA, te_hit & te_qs, "R6");
    expect_at(1, S_L, te_hit & te_qs, "R6");
    expect_at(1, S_N, 1'b0, "R10");
    te_hit = 1'b0;
    step();
    rx_m_stb = 1'b0; rx_s_stb = 1'b0;
    rx_fa_stb = 1'b1; rx_fa = fa;
    expect_at(1, S_MSB, mv, "R8");
    step();
    rx_fa_stb = 1'b0; rx_n_stb = 1'b1; rx_n = n;
    te_hit = fa & ~n;
    step();
    rx_n_stb = 1'b0; half_frame = 1'b0; maint_in = qv;
    te_qs = qv;
    expect_at(1, S_MSB, sv, "R8");
    expect_at(1, S_MARK, mark_out, "R5");
    step();
    maint_in = ~qv;                     // R6: ignored away from the falling edge
    step();
  endtask

  initial begin
    do_reset(1'b1);
    nt_frame(1'b0, 1'b1, 1'b1, 1'b0);
    nt_frame(1'b1, 1'b1, 1'b0, 1'b1);
    nt_frame(1'b0, 1'b1, 1'b1, 1'b1);
    nt_frame(1'b0, 1'b0, 1'b0, 1'b0);
    nt_frame(1'b1, 1'b1, 1'b1, 1'b0);
    nt_frame(1'b1, 1'b0, 1'b0, 1'b1);
    nt_frame(1'b0, 1'b1, 1'b1, 1'b1);
    nt_frame(1'b0, 1'b0, 1'b0, 1'b0);

    do_reset(1'b0);
    te_hit = 1'b0; te_qs = 1'b0;
    te_frame(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    te_frame(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    te_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    te_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    te_frame(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    te_frame(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    te_frame(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);

    step(); step(); step();
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R1 pending items actual=%0d expected=0", sbq.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule